// File: doc/BRIEF.md
# Presettable Up Counter with Terminal-Count Reload

This block is a synchronous binary up counter, eight bits wide by default, with a parallel preset path and an active-low terminal-count flag. The flag goes low while every count bit is one. A stage can be chained to a following stage by wiring its flag into the next stage's active-low count enable, which gives a wider counter.

A reload-select input turns the counter into a programmable divider. While reload-select is low, the counter runs freely and wraps from all-ones to zero. While it is high and counting is enabled, reaching all-ones makes the next clock edge load the preset value instead of wrapping. The flag then pulses once every (2^WIDTH − preset) enabled cycles, with no logic outside the block. An asynchronous master reset clears the count at any time.

Top module: `presetCounter`

## Requirements
- R1: While `mrst` is high, `count` is zero and `termN` is high. The clear takes effect as soon as `mrst` rises, without waiting for a clock edge.
- R2: `termN` is low exactly when `count` is all-ones. It is decoded from the registered count, so it is valid for the whole cycle.
- R3: With `loadEn` low and `cntEnN` low, each rising clock edge adds one to `count`, except in the case covered by R6. With `reloadSel` low, all-ones wraps to zero.
- R4: With `loadEn` low and `cntEnN` high, `count` holds. This applies even at all-ones with `reloadSel` high, so a held counter never reloads.
- R5: With `loadEn` high, the next rising edge loads `preset` into `count`, whatever the values of `cntEnN` and `reloadSel`. The explicit load ranks below reset and above the automatic reload and counting.
- R6: With `loadEn` low, `cntEnN` low, `reloadSel` high and `count` all-ones, the next rising edge loads `preset` instead of wrapping.
- R7: With `reloadSel` high, counting enabled and preset value P, `termN` is low for one cycle in every 2^WIDTH − P cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| mrst | input | 1 | Asynchronous master reset, active high |
| loadEn | input | 1 | Parallel-load enable, active high |
| cntEnN | input | 1 | Count enable, active low |
| reloadSel | input | 1 | High enables the automatic reload at terminal count; tie low when unused |
| preset | input | WIDTH | Value taken by an explicit or automatic load |
| count | output | WIDTH | Registered count |
| termN | output | 1 | Terminal-count flag, low while count is all-ones |

## Verification
The explicit parallel load and the automatic terminal-count reload can be requested in the same cycle. So can the automatic reload and a held count enable. The bench drives the counter to all-ones with `reloadSel` high. In one cycle it raises `loadEn` together with a preset that differs from the earlier one. In another it deasserts the count enable. The load case is judged by the new preset being taken, and the hold case by the count staying at all-ones and not reloading. The master reset is also raised between clock edges, and the bench checks that the count clears before the next edge.

// File: rtl/presetCntPkg.sv
package presetCntPkg;
  // Strobes from control to datapath; at most one is set per cycle.
  typedef struct packed {
    logic doLoad;    // explicit parallel load
    logic doReload;  // automatic reload at terminal count
    logic doInc;     // increment by one
  } cntStrobe_t;
endpackage

// File: rtl/presetCntCtl.sv
module presetCntCtl
  import presetCntPkg::*;
(
  input  logic       loadEn,
  input  logic       cntEnN,
  input  logic       reloadSel,
  input  logic       termN,
  output cntStrobe_t stb
);
  // Priority: explicit load, then gated reload, then gated increment.
  always_comb begin
    stb = '0;
    if (loadEn) begin
      stb.doLoad = 1'b1;
    end else if (!cntEnN) begin
      if (reloadSel && !termN) stb.doReload = 1'b1;
      else                     stb.doInc    = 1'b1;
    end
  end
endmodule

// File: rtl/presetCntDp.sv
module presetCntDp
  import presetCntPkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             mrst,
  input  cntStrobe_t       stb,
  input  logic [WIDTH-1:0] preset,
  output logic [WIDTH-1:0] count,
  output logic             termN
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  logic [WIDTH-1:0] cntQ;

  always_ff @(posedge clk or posedge mrst) begin
    if (mrst)                          cntQ <= '0;
    else if (stb.doLoad || stb.doReload) cntQ <= preset;
    else if (stb.doInc)                cntQ <= cntQ + ONE;
  end

  assign count = cntQ;
  assign termN = ~(&cntQ);
endmodule

// File: rtl/presetCounter.sv
module presetCounter
  import presetCntPkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             mrst,
  input  logic             loadEn,
  input  logic             cntEnN,
  input  logic             reloadSel,
  input  logic [WIDTH-1:0] preset,
  output logic [WIDTH-1:0] count,
  output logic             termN
);
  cntStrobe_t stb;

  presetCntCtl uCtl (
    .loadEn    (loadEn),
    .cntEnN    (cntEnN),
    .reloadSel (reloadSel),
    .termN     (termN),
    .stb       (stb)
  );

  presetCntDp #(.WIDTH(WIDTH)) uDp (
    .clk    (clk),
    .mrst   (mrst),
    .stb    (stb),
    .preset (preset),
    .count  (count),
    .termN  (termN)
  );
endmodule

// File: rtl/presetCounterChk.sv
module presetCounterChk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             mrst,
  input logic             loadEn,
  input logic             cntEnN,
  input logic             reloadSel,
  input logic [WIDTH-1:0] preset,
  input logic [WIDTH-1:0] count,
  input logic             termN
);
  always @(posedge clk) begin
    if (mrst) AST_RESET_CLEAR: assert (count == '0 && termN); // R1
  end

  AST_LOAD_TAKES_PRESET: assert property (@(posedge clk) disable iff (mrst)
    loadEn |=> count == $past(preset)); // R5

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (mrst)
    (!loadEn && cntEnN) |=> $stable(count)); // R4

  AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (mrst)
    (!loadEn && !cntEnN && !(reloadSel && count == '1))
      |=> count == WIDTH'($past(count) + 1'b1)); // R3

  AST_AUTO_RELOAD: assert property (@(posedge clk) disable iff (mrst)
    (!loadEn && !cntEnN && reloadSel && !termN) |=> count == $past(preset)); // R6
endmodule

bind presetCounter presetCounterChk #(.WIDTH(WIDTH)) uChk (
  .clk(clk), .mrst(mrst), .loadEn(loadEn), .cntEnN(cntEnN),
  .reloadSel(reloadSel), .preset(preset), .count(count), .termN(termN)
);

// File: tb/sim_presetCounter.sv
module sim_presetCounter;
  localparam int CLK_P = 10;
  localparam int NVEC  = 12;

  logic       clk = 1'b0;
  logic       mrst, loadEn, cntEnN, reloadSel;
  logic [7:0] preset, count;
  logic       termN;
  int         nRun = 0, nFail = 0;

  always #(CLK_P/2) clk = ~clk;

  presetCounter #(.WIDTH(8)) u0 (
    .clk(clk), .mrst(mrst), .loadEn(loadEn), .cntEnN(cntEnN),
    .reloadSel(reloadSel), .preset(preset), .count(count), .termN(termN)
  );

  // {reqId[3:0], loadEn, cntEnN, reloadSel, preset[7:0], expCount[7:0]}
  localparam logic [22:0] VEC [NVEC] = '{
    {4'd5, 1'b1, 1'b1, 1'b0, 8'hFD, 8'hFD},  // R5 load while disabled
    {4'd3, 1'b0, 1'b0, 1'b0, 8'h00, 8'hFE},  // R3
    {4'd3, 1'b0, 1'b0, 1'b0, 8'h00, 8'hFF},  // R3, R2 flag low
    {4'd3, 1'b0, 1'b0, 1'b0, 8'h55, 8'h00},  // R3 wrap
    {4'd5, 1'b1, 1'b0, 1'b1, 8'hFE, 8'hFE},  // R5 load while enabled
    {4'd3, 1'b0, 1'b0, 1'b1, 8'h10, 8'hFF},  // R3
    {4'd4, 1'b0, 1'b1, 1'b1, 8'h10, 8'hFF},  // R4 held, no reload
    {4'd6, 1'b0, 1'b0, 1'b1, 8'h10, 8'h10},  // R6 auto reload
    {4'd4, 1'b0, 1'b1, 1'b0, 8'h77, 8'h10},  // R4 hold
    {4'd5, 1'b1, 1'b0, 1'b1, 8'hFF, 8'hFF},  // R5
    {4'd5, 1'b1, 1'b0, 1'b1, 8'hAA, 8'hAA},  // R5 load beats reload
    {4'd3, 1'b0, 1'b0, 1'b0, 8'h00, 8'hAB}   // R3
  };

  task automatic check(input string req, input int act, input int exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  endtask

  initial begin
    #(CLK_P * 100000);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    int hits, firstHit, secondHit;
    mrst = 1'b1; loadEn = 1'b0; cntEnN = 1'b1; reloadSel = 1'b0; preset = '0;
    repeat (2) @(negedge clk);
    check("R1 count", count, 0);
    check("R1 termN", termN, 1);
    mrst = 1'b0;

    for (int i = 0; i < NVEC; i++) begin
      loadEn    = VEC[i][18];
      cntEnN    = VEC[i][17];
      reloadSel = VEC[i][16];
      preset    = VEC[i][15:8];
      @(negedge clk);
      check($sformatf("R%0d vec%0d count", VEC[i][22:19], i), count, VEC[i][7:0]);
      check($sformatf("R2 vec%0d termN", i), termN, (VEC[i][7:0] == 8'hFF) ? 0 : 1);
    end

    // R1: asynchronous clear between edges
    cntEnN = 1'b1; loadEn = 1'b0;
    #2 mrst = 1'b1;
    #1 check("R1 async count", count, 0);
    check("R1 async termN", termN, 1);
    @(negedge clk);
    mrst = 1'b0;

    // R7: divide by 16 with preset F0
    loadEn = 1'b1; preset = 8'hF0; reloadSel = 1'b1; cntEnN = 1'b0;
    @(negedge clk);
    loadEn = 1'b0;
    hits = 0; firstHit = -1; secondHit = -1;
    for (int c = 0; c < 64; c++) begin
      @(negedge clk);
      if (!termN) begin
        if (hits == 0) firstHit = c;
        else if (hits == 1) secondHit = c;
        hits++;
      end
    end
    check("R7 pulse count", hits, 4);
    check("R7 pulse spacing", secondHit - firstHit, 16);

    finishRun();
  end
endmodule